// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel together with the logic that decodes its configuration byte. A host writes one control byte, which names the channel, how count bytes are transferred, the counting mode and the number base. It then writes the initial count as one or two bytes. From then on the channel counts on the rising edge of `clk`. It drives `out` according to the selected mode and takes a `gate` input that either enables counting or triggers it, depending on the mode.

Six modes are provided:

- terminal-count signalling
- a retriggerable one-shot
- a rate divider
- a square-wave generator that handles odd counts
- a strobe started by software
- a strobe started by hardware

The count can run in plain binary or in four-digit BCD. A latch command freezes a snapshot of the count, which the host reads back a byte at a time while counting continues.

Top module: `pit_channel`

## Requirements
- R1: A control byte (wr_en=1, wr_ctrl=1) is accepted only when its bits 7:6 equal the CHAN_SEL parameter (default 00). The value 11 in bits 7:6 is never accepted. A byte that is not accepted leaves the mode, count and `out` unchanged.
- R2: Control bits 5:4 set the count transfer. 01 means the low byte only, with the high byte taken as zero. 10 means the high byte only, with the low byte taken as zero. 11 means the low byte and then the high byte. The same setting governs read-back: 01 returns the low byte, 10 returns the high byte, and 11 returns the low byte and then the high byte.
- R3: Control bits 3:1 choose the mode. 000 selects mode 0 and 001 selects mode 1. Patterns x10 select mode 2 and patterns x11 select mode 3, whatever bit 3 holds. 100 selects mode 4 and 101 selects mode 5.
- R4: With control bit 0 at 1 the counter decrements in BCD, so 0x0100 becomes 0x0099. With bit 0 at 0 it decrements in binary, so 0x0100 becomes 0x00FF.
- R5: In mode 0, `out` goes low on the edge that writes the control byte and again on the edge that completes a new count. The count N is loaded one clock later and decrements only while `gate` is 1. `out` rises on the edge where the count goes from 1 to 0 and stays high after that.
- R6: In mode 1, `out` idles high. On the edge where `gate` is seen rising after a count has been written, `out` falls and the count is loaded. `out` rises N clocks later. A later rising edge of `gate` starts the pulse again.
- R7: In mode 2 with `gate` high, `out` is low for one clock in every N, and the count reloads by itself. `gate` low holds `out` high and stops counting.
- R8: In mode 3 with `gate` high, `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks, repeating. `gate` low forces `out` high on the next edge and stops counting.
- R9: In mode 4, once a count is written and loaded, `out` goes low for exactly one clock as the count reaches zero. `gate` low keeps the count frozen and `out` high.
- R10: In mode 5, writing a count does not load it. The count is loaded on the edge where `gate` is seen rising. `out` goes low for one clock N edges later and then returns high.
- R11: A written count of 0 acts as the largest count, so the first decrement gives 0xFFFF in binary or 0x9999 in BCD.
- R12: With two-byte transfer, writing only the low byte does not start counting. Counting begins one clock after the high byte arrives.
- R13: A control byte with bits 5:4 equal to 00 (latch) copies the count into a holding register. Reads return that snapshot until it has been read in full, even while counting continues. After that, reads return the live count.
- R14: During and after reset, `out` is high, the count is zero and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_ctrl | input | 1 | 1: the byte is a control byte; 0: the byte is a count byte |
| wr_data | input | 8 | Byte being written |
| rd_en | input | 1 | Consumes the byte shown on `rd_data` |
| rd_data | output | 8 | Count byte selected by the transfer setting and the read order |
| gate | input | 1 | Count enable or trigger, depending on the mode |
| out | output | 1 | Timer output, registered |

## Verification
The hardest states to reach are the odd-count square wave and the latch snapshot. The odd-count case needs a padding clock in the high phase only. The latch case needs the live count to keep moving while the snapshot is read out. The stimulus sets up a 5-count and a 6-count square wave with `gate` already high. It then compares every clock against the expected high and low run lengths, and drops `gate` in a low phase so that the forced-high response can be seen. For the latch case, the count is loaded with `gate` low so its value is known. The count is latched, then `gate` is opened for exactly ten clocks before both the snapshot and the live value are read back. BCD borrow and the zero-means-maximum rule are reached by opening `gate` for exactly one clock.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_t;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_t;
endpackage

// File: rtl/pit_cw_decode.sv
`timescale 1ns/1ps
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'b00
) (
  input  logic              strobe,
  input  logic [BYTE_W-1:0] cw,
  output logic              cfg_we,
  output logic              latch_we,
  output mode_t             mode,
  output acc_t              acc,
  output logic              bcd
);
  logic hit;

  // select field 11 is a broadcast read-back command: never ours
  assign hit      = strobe && (cw[7:6] == CHAN_SEL) && (cw[7:6] != 2'b11);
  assign acc      = acc_t'(cw[5:4]);
  assign cfg_we   = hit && (acc != ACC_LATCH);
  assign latch_we = hit && (acc == ACC_LATCH);
  assign bcd      = cw[0];
  // when the middle mode bit is set, the top mode bit is a don't-care
  assign mode     = cw[2] ? mode_t'({1'b0, cw[2:1]}) : mode_t'(cw[3:1]);
endmodule

// File: rtl/pit_dec_unit.sv
`timescale 1ns/1ps
module pit_dec_unit
  import pit_pkg::*;
(
  input  logic [CNT_W-1:0] val,
  input  logic             bcd,
  output logic [CNT_W-1:0] res
);
  logic [DIGITS-1:0] borrow;
  logic [CNT_W-1:0]  bcd_res;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    assign d = val[4*g +: 4];
    assign bcd_res[4*g +: 4] = !borrow[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] && (d == 4'd0);
    end
  end

  assign res = bcd ? bcd_res : (val - CNT_W'(1));
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              gate,
  output logic              out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  mode_t            mode_q;
  acc_t             acc_q;
  logic             bcd_q;
  logic [CNT_W-1:0] cr_q, cr_nxt, ce_q, ol_q;
  logic             latched_q, hi_next_q, hi_next_nxt, rd_hi_q;
  logic             load_pend_q, armed_q, run_q, fired_q, pad_q, gate_q, out_q;

  logic             cfg_we, latch_we, cw_bcd, cnt_we, cnt_done, trig;
  mode_t            cw_mode;
  acc_t             cw_acc;
  logic [CNT_W-1:0] dec1, dec2, ce_even, rd_src;
  logic             ce_is1, ce_is2;

  pit_cw_decode #(.CHAN_SEL(CHAN_SEL)) i_decode (
    .strobe  (wr_en && wr_ctrl),
    .cw      (wr_data),
    .cfg_we  (cfg_we),
    .latch_we(latch_we),
    .mode    (cw_mode),
    .acc     (cw_acc),
    .bcd     (cw_bcd)
  );

  // two chained decrementers: step by one, and by two for the square wave
  pit_dec_unit i_dec1 (.val(ce_q), .bcd(bcd_q), .res(dec1));
  pit_dec_unit i_dec2 (.val(dec1), .bcd(bcd_q), .res(dec2));

  assign cnt_we  = wr_en && !wr_ctrl;
  assign trig    = gate && !gate_q;
  assign ce_is1  = (ce_q == ONE);
  assign ce_is2  = (ce_q == TWO);
  assign ce_even = {cr_q[CNT_W-1:1], 1'b0};

  // count byte assembly
  always_comb begin
    cr_nxt      = cr_q;
    hi_next_nxt = hi_next_q;
    cnt_done    = 1'b0;
    if (cnt_we) begin
      case (acc_q)
        ACC_LO: begin
          cr_nxt   = {{BYTE_W{1'b0}}, wr_data};
          cnt_done = 1'b1;
        end
        ACC_HI: begin
          cr_nxt   = {wr_data, {BYTE_W{1'b0}}};
          cnt_done = 1'b1;
        end
        ACC_BOTH: begin
          if (!hi_next_q) begin
            cr_nxt[BYTE_W-1:0] = wr_data;
            hi_next_nxt        = 1'b1;
          end else begin
            cr_nxt[CNT_W-1:BYTE_W] = wr_data;
            hi_next_nxt            = 1'b0;
            cnt_done               = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // read-back byte selection
  always_comb begin
    rd_src = latched_q ? ol_q : ce_q;
    case (acc_q)
      ACC_HI:   rd_data = rd_src[CNT_W-1:BYTE_W];
      ACC_BOTH: rd_data = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default:  rd_data = rd_src[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_TERM;
      acc_q       <= ACC_LO;
      bcd_q       <= 1'b0;
      cr_q        <= '0;
      ce_q        <= '0;
      ol_q        <= '0;
      latched_q   <= 1'b0;
      hi_next_q   <= 1'b0;
      rd_hi_q     <= 1'b0;
      load_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      run_q       <= 1'b0;
      fired_q     <= 1'b0;
      pad_q       <= 1'b0;
      gate_q      <= 1'b0;
      out_q       <= 1'b1;
    end else begin
      gate_q    <= gate;
      cr_q      <= cr_nxt;
      hi_next_q <= hi_next_nxt;

      if (rd_en) begin
        if (acc_q == ACC_BOTH && !rd_hi_q) begin
          rd_hi_q <= 1'b1;
        end else begin
          rd_hi_q   <= 1'b0;
          latched_q <= 1'b0;
        end
      end
      if (latch_we && !latched_q) begin
        ol_q      <= ce_q;
        latched_q <= 1'b1;
      end

      // counting element, driven by the state before this cycle's writes
      if (load_pend_q) begin
        load_pend_q <= 1'b0;
        run_q       <= 1'b1;
        fired_q     <= 1'b0;
        pad_q       <= 1'b0;
        ce_q        <= (mode_q == M_SQUARE) ? ce_even : cr_q;
        if (mode_q != M_TERM) out_q <= 1'b1;
      end else if (trig && armed_q && (mode_q inside {M_ONESHOT, M_RATE, M_SQUARE, M_HWSTROBE})) begin
        run_q   <= 1'b1;
        fired_q <= 1'b0;
        pad_q   <= 1'b0;
        ce_q    <= (mode_q == M_SQUARE) ? ce_even : cr_q;
        out_q   <= (mode_q != M_ONESHOT);
      end else if (run_q) begin
        case (mode_q)
          M_TERM: if (gate) begin
            ce_q <= dec1;
            if (ce_is1 && !fired_q) begin
              out_q   <= 1'b1;
              fired_q <= 1'b1;
            end
          end
          M_ONESHOT: begin
            ce_q <= dec1;
            if (ce_is1 && !fired_q) begin
              out_q   <= 1'b1;
              fired_q <= 1'b1;
            end
          end
          M_RATE: begin
            if (!gate) begin
              out_q <= 1'b1;
            end else if (ce_is1) begin
              ce_q  <= cr_q;
              out_q <= 1'b1;
            end else begin
              ce_q <= dec1;
              if (ce_is2) out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (!gate) begin
              out_q <= 1'b1;
            end else if (ce_is2) begin
              if (out_q && cr_q[0] && !pad_q) begin
                pad_q <= 1'b1;
              end else begin
                pad_q <= 1'b0;
                out_q <= !out_q;
                ce_q  <= ce_even;
              end
            end else begin
              ce_q <= dec2;
            end
          end
          M_SWSTROBE, M_HWSTROBE: begin
            out_q <= 1'b1;
            if (gate || mode_q == M_HWSTROBE) begin
              ce_q <= dec1;
              if (ce_is1 && !fired_q) begin
                out_q   <= 1'b0;
                fired_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end

      // count writes take priority over counting
      if (cnt_we && acc_q == ACC_BOTH && !hi_next_q && mode_q == M_TERM) run_q <= 1'b0;
      if (cnt_done) begin
        armed_q <= 1'b1;
        if (mode_q == M_TERM) out_q <= 1'b0;
        if (!(mode_q inside {M_ONESHOT, M_HWSTROBE})) load_pend_q <= 1'b1;
      end

      // a new configuration overrides everything
      if (cfg_we) begin
        mode_q      <= cw_mode;
        acc_q       <= cw_acc;
        bcd_q       <= cw_bcd;
        hi_next_q   <= 1'b0;
        rd_hi_q     <= 1'b0;
        latched_q   <= 1'b0;
        load_pend_q <= 1'b0;
        armed_q     <= 1'b0;
        run_q       <= 1'b0;
        fired_q     <= 1'b0;
        pad_q       <= 1'b0;
        out_q       <= (cw_mode != M_TERM);
      end
    end
  end

  assign out = out_q;
endmodule

// File: rtl/pit_channel_checker.sv
`timescale 1ns/1ps
module pit_channel_checker
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_ctrl,
  input logic             rd_en,
  input logic             gate,
  input logic             out,
  input logic             cfg_we,
  input mode_t            cw_mode,
  input mode_t            mode_q,
  input logic             armed_q,
  input logic             latched_q,
  input logic [CNT_W-1:0] ol_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && wr_ctrl;

  // R14: reset leaves the output high
  a_r14_reset_high: assert property (@(posedge clk) rst |=> out);

  // R5: accepting a mode-0 configuration drops the output
  a_r5_cfg_drops_out: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cw_mode == M_TERM) |=> !out);

  // R6: a gate rise on an armed one-shot starts the low pulse
  a_r6_trigger_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ONESHOT && armed_q && $rose(gate) && !ctrl_wr) |=> !out);

  // R7: the rate divider's low phase lasts one clock
  a_r7_rate_low_one: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RATE && !out && !ctrl_wr) |=> out);

  // R9 and R10: strobes last one clock
  a_r9_strobe_one_clk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out && !ctrl_wr) |=> out);

  // R13: a held snapshot does not move until it is read out
  a_r13_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !rd_en && !ctrl_wr) |=> (latched_q && $stable(ol_q)));
endmodule

bind pit_channel pit_channel_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_ctrl  (wr_ctrl),
  .rd_en    (rd_en),
  .gate     (gate),
  .out      (out),
  .cfg_we   (cfg_we),
  .cw_mode  (cw_mode),
  .mode_q   (mode_q),
  .armed_q  (armed_q),
  .latched_q(latched_q),
  .ol_q     (ol_q)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       gate = 1'b0;
  logic       out;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  pit_channel i_pit_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .gate(gate), .out(out)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic ctrl, input logic [7:0] b);
    wr_en = 1'b1; wr_ctrl = ctrl; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_ctrl = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    #1 v = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R14 out after reset", out, 1);
    check("R14 rd_data after reset", rd_data, 0);
  endtask

  task automatic t_mode0_and_select();
    gate = 1'b0;
    wr_byte(1'b1, 8'h10);
    check("R5 out low after control byte", out, 0);
    wr_byte(1'b0, 8'd3);
    step(8);
    check("R5 gate low holds out low", out, 0);
    gate = 1'b1;
    step(2);
    check("R5 out still low before terminal", out, 0);
    step(1);
    check("R5 out high at terminal", out, 1);
    wr_byte(1'b1, 8'h50);
    check("R1 other channel ignored", out, 1);
    wr_byte(1'b1, 8'hD0);
    check("R1 select 11 ignored", out, 1);
    wr_byte(1'b0, 8'd5);
    check("R5 new count drops out", out, 0);
    gate = 1'b0;
  endtask

  task automatic t_high_only();
    gate = 1'b1;
    wr_byte(1'b1, 8'h20);
    wr_byte(1'b0, 8'h01);
    step(256);
    check("R2 high-only count 256 not yet expired", out, 0);
    step(1);
    check("R2 high-only count 256 expired", out, 1);
    gate = 1'b0;
  endtask

  task automatic t_partial();
    gate = 1'b1;
    wr_byte(1'b1, 8'h30);
    wr_byte(1'b0, 8'h02);
    step(6);
    check("R12 low byte alone does not count", out, 0);
    wr_byte(1'b0, 8'h00);
    step(2);
    check("R12 counting after high byte, before end", out, 0);
    step(1);
    check("R12 terminal after high byte", out, 1);
    gate = 1'b0;
  endtask

  task automatic t_oneshot();
    gate = 1'b0;
    step(1);
    wr_byte(1'b1, 8'h12);
    check("R6 idle high", out, 1);
    wr_byte(1'b0, 8'd4);
    step(3);
    check("R6 no trigger no pulse", out, 1);
    gate = 1'b1;
    step(1);
    check("R6 low after trigger", out, 0);
    step(3);
    check("R6 still low", out, 0);
    step(1);
    check("R6 high after N clocks", out, 1);
    gate = 1'b0;
    step(1);
    gate = 1'b1;
    step(1);
    check("R6 retrigger", out, 0);
    gate = 1'b0;
  endtask

  task automatic t_rate();
    gate = 1'b1;
    step(1);
    wr_byte(1'b1, 8'h1C);
    wr_byte(1'b0, 8'd4);
    for (int k = 1; k <= 12; k++) begin
      step(1);
      check($sformatf("R7 R3 rate divider clock %0d", k), out, (k % 4 != 0) ? 1 : 0);
    end
    gate = 1'b0;
  endtask

  task automatic t_square(input logic [7:0] cw, input int n);
    gate = 1'b1;
    step(1);
    wr_byte(1'b1, cw);
    wr_byte(1'b0, n[7:0]);
    for (int k = 1; k <= 2 * n; k++) begin
      step(1);
      check($sformatf("R8 R3 square N=%0d clock %0d", n, k), out,
            (((k - 1) % n) < ((n + 1) / 2)) ? 1 : 0);
    end
    gate = 1'b0;
    step(1);
    check("R8 gate low forces high", out, 1);
  endtask

  task automatic t_sw_strobe();
    logic [7:0] v;
    gate = 1'b1;
    wr_byte(1'b1, 8'h18);
    wr_byte(1'b0, 8'd3);
    step(3);
    check("R9 high before expiry", out, 1);
    step(1);
    check("R9 strobe low", out, 0);
    step(1);
    check("R9 strobe one clock", out, 1);
    gate = 1'b0;
    wr_byte(1'b0, 8'd3);
    step(10);
    check("R9 gate low no strobe", out, 1);
    rd_byte(v);
    check("R9 gate low count frozen", v, 3);
  endtask

  task automatic t_hw_strobe();
    gate = 1'b0;
    step(1);
    wr_byte(1'b1, 8'h1A);
    wr_byte(1'b0, 8'd3);
    step(5);
    check("R10 no trigger no strobe", out, 1);
    gate = 1'b1;
    step(3);
    check("R10 high before expiry", out, 1);
    step(1);
    check("R10 strobe low", out, 0);
    step(1);
    check("R10 strobe one clock", out, 1);
    gate = 1'b0;
  endtask

  task automatic one_count(input logic [7:0] cw, input logic [7:0] lo, input logic [7:0] hi,
                           output logic [15:0] res);
    logic [7:0] a, b;
    gate = 1'b0;
    wr_byte(1'b1, cw);
    wr_byte(1'b0, lo);
    wr_byte(1'b0, hi);
    step(1);
    gate = 1'b1;
    step(1);
    gate = 1'b0;
    rd_byte(a);
    rd_byte(b);
    res = {b, a};
  endtask

  task automatic t_bases();
    logic [15:0] r;
    one_count(8'h31, 8'h00, 8'h01, r);
    check("R4 BCD borrow 0100", r, 16'h0099);
    one_count(8'h30, 8'h00, 8'h01, r);
    check("R4 binary borrow 0100", r, 16'h00FF);
    one_count(8'h31, 8'h00, 8'h00, r);
    check("R11 zero as max BCD", r, 16'h9999);
    one_count(8'h30, 8'h00, 8'h00, r);
    check("R11 zero as max binary", r, 16'hFFFF);
  endtask

  task automatic t_latch();
    logic [7:0] a, b;
    gate = 1'b0;
    wr_byte(1'b1, 8'h30);
    wr_byte(1'b0, 8'h34);
    wr_byte(1'b0, 8'h12);
    step(1);
    wr_byte(1'b1, 8'h00);
    gate = 1'b1;
    step(10);
    gate = 1'b0;
    rd_byte(a);
    rd_byte(b);
    check("R13 snapshot", {b, a}, 16'h1234);
    rd_byte(a);
    rd_byte(b);
    check("R13 live after snapshot read", {b, a}, 16'h122A);
  endtask

  initial begin
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_mode0_and_select();
    t_high_only();
    t_partial();
    t_oneshot();
    t_rate();
    t_square(8'h1E, 5);
    t_square(8'h16, 6);
    t_sw_strobe();
    t_hw_strobe();
    t_bases();
    t_latch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule